// File: doc/BRIEF.md
# Memory-Mapped Flash Direct Access Sequencer

This block converts one bus access into a flash address window into a complete serial-flash command sequence on a byte-wide transfer port. The upper request address bits pick one of several flash devices; the lower bits are the byte offset inside that device's 128 MiB window. For each accepted access the block pulls the chosen device's select low, sends a command byte, the address bytes, and on reads a run of zero dummy bytes. It then moves 1 to 8 data bytes and raises the select again before it presents the response.

Two 32-bit configuration words arrive as plain inputs, one used for reads and one for writes. Both share one layout: command byte in bits 7:0, access-type code in bits 9:8, dummy-width code in bits 13:12 and address-size code in bits 17:16. The word that applies is captured when a request is accepted, so it may change while an access is running. The byte shifter sits outside: it takes `xfer_tx` while `xfer_valid` is high and answers with a one-cycle `xfer_done` pulse that carries the received byte on `xfer_rx`.

Both bus channels are valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when no access or response is pending. A response stays on `rsp_valid` with unchanged payload until `rsp_ready` is seen high. The byte port has no ready signal; `xfer_valid` and `xfer_tx` stay put until the shifter signals done.

Top module: `flash_direct_seq`

## Requirements
- R1: The first byte of every sequence is the command byte: `rd_cfg[7:0]` for a read (`req_write`=0) and `wr_cfg[7:0]` for a write (`req_write`=1).
- R2: Address-size code (bits 17:16 of the applied word) 0 sends 3 address bytes and code 1 sends 4. The bytes are taken from the window offset `req_addr[26:0]` zero-extended to 32 bits, most significant byte first.
- R3: Address-size codes 2 and 3 send no address bytes and return `rsp_err_asize`=1. The rest of the sequence still runs. Valid codes return `rsp_err_asize`=0.
- R4: A read sends (D*8) >> A dummy bytes, each 0x00, after the address. D is `rd_cfg[13:12]` and A is `rd_cfg[9:8]`.
- R5: `req_len` holds the byte count minus one, so 0 to 7 means 1 to 8 bytes. On a write, byte i of `req_wdata` (bits 8i+7:8i) is sent for i = 0 upward. A read sends 0x00 for each data byte. The byte received for data transfer i lands in `rsp_rdata[8i+7:8i]`, and the bits above the last byte read as zero.
- R6: A write sends no dummy bytes, whatever its configuration word holds. The data bytes follow the address directly.
- R7: `cs_n[k]`, with k = `req_addr[27]`, goes low in the cycle after acceptance. It stays low through every byte of the sequence and is high again when `rsp_valid` rises. At most one select is ever low.
- R8: If `other_cs_active` is high when a request is accepted, the response carries `rsp_err_busy`=1. Otherwise it carries 0. The access runs either way.
- R9: `req_ready` is low from acceptance until the response handshake completes. `rsp_valid` and its payload hold until `rsp_ready`. `xfer_valid` and `xfer_tx` hold until `xfer_done`.
- R10: After reset, every `cs_n` bit is high, `xfer_valid` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_cfg | input | 32 | Configuration word applied to reads |
| wr_cfg | input | 32 | Configuration word applied to writes |
| other_cs_active | input | 1 | Another master already holds a flash select |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 28 | Device select bit 27, window offset 26:0 |
| req_len | input | 3 | Byte count minus one |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | 64 | Read data, little-endian, zero above the last byte |
| rsp_err_asize | output | 1 | Address-size code was not 0 or 1 |
| rsp_err_busy | output | 1 | Another select was active at acceptance |
| xfer_valid | output | 1 | A byte is offered to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | One-cycle pulse: byte exchanged |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| cs_n | output | 2 | Active-low device selects |

## Verification
The assertions assume that `xfer_done` pulses for a single cycle and only while `xfer_valid` is high. They also assume that the request fields stay steady while `req_valid` waits for `req_ready`. The bench's shifter model follows both rules: it answers each offered byte once, after 0 to 2 idle cycles, and drops done straight after. Requests are driven only after `req_ready` is seen high and are released after one edge. The response side is stalled for several cycles on some accesses to exercise the hold rules.

// File: rtl/fds_pkg.sv
package fds_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_RESP  = 3'd5
  } fds_phase_e;

  localparam int CMD_LSB   = 0;
  localparam int ACC_LSB   = 8;
  localparam int DBW_LSB   = 12;
  localparam int ASIZE_LSB = 16;

  typedef struct packed {
    logic [7:0] cmd;
    logic [2:0] n_addr;
    logic [4:0] n_dummy;
    logic       bad_asize;
  } fds_plan_t;

endpackage

// File: rtl/fds_decode.sv
module fds_decode
  import fds_pkg::*;
(
  input  logic        is_write,
  input  logic [31:0] rd_cfg,
  input  logic [31:0] wr_cfg,
  output fds_plan_t   plan
);

  logic [31:0] cfg;
  logic [1:0]  asize;
  logic [1:0]  dbw;
  logic [1:0]  acc;
  logic [4:0]  dummy_raw;

  always_comb begin
    cfg       = is_write ? wr_cfg : rd_cfg;
    asize     = cfg[ASIZE_LSB +: 2];
    dbw       = cfg[DBW_LSB +: 2];
    acc       = cfg[ACC_LSB +: 2];
    dummy_raw = {dbw, 3'b000} >> acc;

    plan.cmd = cfg[CMD_LSB +: 8];
    unique case (asize)
      2'd0: begin plan.n_addr = 3'd3; plan.bad_asize = 1'b0; end
      2'd1: begin plan.n_addr = 3'd4; plan.bad_asize = 1'b0; end
      default: begin plan.n_addr = 3'd0; plan.bad_asize = 1'b1; end
    endcase
    plan.n_dummy = is_write ? 5'd0 : dummy_raw;
  end

endmodule

// File: rtl/fds_lanes.sv
module fds_lanes #(
  parameter int MAX_BYTES = 8,
  localparam int LEN_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int DATA_W = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_wdata,
  input  logic [LEN_W-1:0]  idx,
  input  logic              cap_en,
  input  logic [7:0]        cap_byte,
  output logic [7:0]        wr_byte,
  output logic [DATA_W-1:0] rdata
);

  logic [7:0] wd [MAX_BYTES];
  logic [7:0] rd [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wd[g] <= 8'h00;
        rd[g] <= 8'h00;
      end else if (load) begin
        wd[g] <= load_wdata[8*g +: 8];
        rd[g] <= 8'h00;
      end else if (cap_en && (idx == LEN_W'(g))) begin
        rd[g] <= cap_byte;
      end
    end
    assign rdata[8*g +: 8] = rd[g];
  end

  assign wr_byte = wd[idx];

endmodule

// File: rtl/fds_ctrl.sv
module fds_ctrl
  import fds_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int WIN_BITS  = 27,
  parameter int MAX_BYTES = 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LEN_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [CS_W-1:0]     req_cs,
  input  logic [WIN_BITS-1:0] req_off,
  input  logic [LEN_W-1:0]    req_len,
  input  logic                other_cs_active,
  input  fds_plan_t           plan_in,
  input  logic                rsp_ready,
  input  logic                xfer_done,
  input  logic [7:0]          wr_byte,
  output logic                req_ready,
  output logic                accept,
  output logic                rsp_valid,
  output logic                err_asize,
  output logic                err_busy,
  output logic                xfer_valid,
  output logic [7:0]          xfer_tx,
  output logic [NUM_CS-1:0]   cs_n,
  output logic [LEN_W-1:0]    byte_idx,
  output logic                cap_en
);

  fds_phase_e        ph;
  fds_plan_t         plan_q;
  logic              wr_q;
  logic [LEN_W-1:0]  len_q;
  logic [31:0]       addr_q;
  logic [4:0]        cnt;
  logic [4:0]        ph_last;
  logic              last_byte;
  fds_phase_e        ph_after;
  fds_phase_e        ph_post_addr;
  logic [31:0]       off_ext;
  logic [2:0]        abyte_idx;
  logic [NUM_CS-1:0] sel_n;

  always_comb begin
    off_ext = '0;
    off_ext[WIN_BITS-1:0] = req_off;
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_sel
    assign sel_n[k] = (req_cs != CS_W'(k));
  end

  assign req_ready  = (ph == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign rsp_valid  = (ph == PH_RESP);
  assign xfer_valid = (ph == PH_CMD) || (ph == PH_ADDR) ||
                      (ph == PH_DUMMY) || (ph == PH_DATA);
  assign byte_idx   = cnt[LEN_W-1:0];
  assign cap_en     = (ph == PH_DATA) && !wr_q && xfer_done;
  assign abyte_idx  = plan_q.n_addr - 3'd1 - cnt[2:0];

  always_comb begin
    unique case (ph)
      PH_CMD:   xfer_tx = plan_q.cmd;
      PH_ADDR:  xfer_tx = addr_q[{abyte_idx[1:0], 3'b000} +: 8];
      PH_DATA:  xfer_tx = wr_q ? wr_byte : 8'h00;
      default:  xfer_tx = 8'h00;
    endcase
  end

  always_comb begin
    unique case (ph)
      PH_ADDR:  ph_last = {2'b00, plan_q.n_addr} - 5'd1;
      PH_DUMMY: ph_last = plan_q.n_dummy - 5'd1;
      PH_DATA:  ph_last = 5'(len_q);
      default:  ph_last = 5'd0;
    endcase
    last_byte = (cnt == ph_last);

    ph_post_addr = (!wr_q && plan_q.n_dummy != 5'd0) ? PH_DUMMY : PH_DATA;
    unique case (ph)
      PH_CMD:   ph_after = (plan_q.n_addr != 3'd0) ? PH_ADDR : ph_post_addr;
      PH_ADDR:  ph_after = ph_post_addr;
      PH_DUMMY: ph_after = PH_DATA;
      default:  ph_after = PH_RESP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      plan_q    <= '0;
      wr_q      <= 1'b0;
      len_q     <= '0;
      addr_q    <= '0;
      cnt       <= '0;
      err_asize <= 1'b0;
      err_busy  <= 1'b0;
      cs_n      <= '1;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (accept) begin
            ph        <= PH_CMD;
            plan_q    <= plan_in;
            wr_q      <= req_write;
            len_q     <= req_len;
            addr_q    <= off_ext;
            cnt       <= '0;
            err_asize <= plan_in.bad_asize;
            err_busy  <= other_cs_active;
            cs_n      <= sel_n;
          end
        end
        PH_RESP: begin
          if (rsp_ready) ph <= PH_IDLE;
        end
        default: begin
          if (xfer_done) begin
            if (last_byte) begin
              ph  <= ph_after;
              cnt <= '0;
              if (ph_after == PH_RESP) cs_n <= '1;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
        end
      endcase
    end
  end

  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_cs_low_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !(&cs_n));

  p_cs_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&cs_n));

  p_xfer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_tx)));

  p_no_wr_dummy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && wr_q) |-> (ph != PH_DUMMY));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !xfer_valid));

endmodule

// File: rtl/flash_direct_seq.sv
module flash_direct_seq
  import fds_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int WIN_BITS  = 27,
  parameter int MAX_BYTES = 8,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LEN_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int ADDR_W = WIN_BITS + CS_W,
  localparam int DATA_W = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       rd_cfg,
  input  logic [31:0]       wr_cfg,
  input  logic              other_cs_active,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err_asize,
  output logic              rsp_err_busy,
  output logic              xfer_valid,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  output logic [NUM_CS-1:0] cs_n
);

  fds_plan_t        plan;
  logic             accept;
  logic [LEN_W-1:0] byte_idx;
  logic             cap_en;
  logic [7:0]       wr_byte;

  fds_decode u_decode (
    .is_write (req_write),
    .rd_cfg   (rd_cfg),
    .wr_cfg   (wr_cfg),
    .plan     (plan)
  );

  fds_ctrl #(
    .NUM_CS    (NUM_CS),
    .WIN_BITS  (WIN_BITS),
    .MAX_BYTES (MAX_BYTES)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_cs          (req_addr[ADDR_W-1:WIN_BITS]),
    .req_off         (req_addr[WIN_BITS-1:0]),
    .req_len         (req_len),
    .other_cs_active (other_cs_active),
    .plan_in         (plan),
    .rsp_ready       (rsp_ready),
    .xfer_done       (xfer_done),
    .wr_byte         (wr_byte),
    .req_ready       (req_ready),
    .accept          (accept),
    .rsp_valid       (rsp_valid),
    .err_asize       (rsp_err_asize),
    .err_busy        (rsp_err_busy),
    .xfer_valid      (xfer_valid),
    .xfer_tx         (xfer_tx),
    .cs_n            (cs_n),
    .byte_idx        (byte_idx),
    .cap_en          (cap_en)
  );

  fds_lanes #(
    .MAX_BYTES (MAX_BYTES)
  ) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_wdata (req_wdata),
    .idx        (byte_idx),
    .cap_en     (cap_en),
    .cap_byte   (xfer_rx),
    .wr_byte    (wr_byte),
    .rdata      (rsp_rdata)
  );

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err_asize) &&
       $stable(rsp_err_busy)));

  p_busy_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: tb/flash_direct_seq_tb.sv
module flash_direct_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rd_cfg = '0, wr_cfg = '0;
  logic        other_cs_active = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [27:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err_asize, rsp_err_busy;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_rdata;
  logic        xfer_valid;
  logic [7:0]  xfer_tx;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = '0;
  logic [1:0]  cs_n;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] tx_q[$], rx_q[$];
  logic [1:0] csq[$];
  logic [1:0] exp_sel = 2'b00;
  int wait_c = 0, rx_n = 0;

  always #2.5 clk = ~clk;

  flash_direct_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rd_cfg(rd_cfg), .wr_cfg(wr_cfg),
    .other_cs_active(other_cs_active), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err_asize(rsp_err_asize), .rsp_err_busy(rsp_err_busy),
    .xfer_valid(xfer_valid), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
    .xfer_rx(xfer_rx), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // shifter model: answers each offered byte after 0..2 idle cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      xfer_done = 1'b0;
    end else if (xfer_done) begin
      xfer_done = 1'b0;
    end else if (xfer_valid) begin
      if (wait_c > 0) wait_c--;
      else begin
        logic [7:0] pat;
        pat = 8'h5A ^ 8'(rx_n * 37);
        tx_q.push_back(xfer_tx);
        csq.push_back(~cs_n);
        rx_q.push_back(pat);
        xfer_rx = pat;
        xfer_done = 1'b1;
        rx_n++;
        wait_c = rx_n % 3;
      end
    end
  end

  // per-clock comparison of the selects against the expected device
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk($onehot0(~cs_n), "R7", "select onehot", 64'(cs_n), 64'h3);
      if (xfer_valid)
        chk((~cs_n) == exp_sel, "R7", "select during byte", 64'(~cs_n), 64'(exp_sel));
      if (rsp_valid)
        chk(cs_n == 2'b11 && !req_ready, "R7", "released at response",
            64'({req_ready, cs_n}), 64'h3);
    end
  end

  task automatic access(input bit wr, input int cs, input logic [26:0] off,
                        input int nb, input logic [63:0] wd,
                        input logic [31:0] rc, input logic [31:0] wc,
                        input bit busy, input int bp, input string tag);
    logic [7:0]  exp_q[$];
    logic [31:0] cfg;
    logic [31:0] off32;
    logic [63:0] exp_rd, held;
    int na, nd, n;
    bit seq_ok, cs_ok;
    cfg = wr ? wc : rc;
    off32 = {5'b0, off};
    na = (cfg[17:16] == 2'd0) ? 3 : (cfg[17:16] == 2'd1) ? 4 : 0;
    nd = wr ? 0 : ((int'(cfg[13:12]) * 8) >> cfg[9:8]);
    exp_q.push_back(cfg[7:0]);
    for (int k = na - 1; k >= 0; k--) exp_q.push_back(off32[8*k +: 8]);
    for (int k = 0; k < nd; k++) exp_q.push_back(8'h00);
    for (int k = 0; k < nb; k++) exp_q.push_back(wr ? wd[8*k +: 8] : 8'h00);

    tx_q.delete(); rx_q.delete(); csq.delete();
    exp_sel = 2'(1 << cs);
    rd_cfg = rc; wr_cfg = wc; other_cs_active = busy;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {1'(cs), off};
    req_len = 3'(nb - 1); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; other_cs_active = 1'b0;
    rd_cfg = ~rc; wr_cfg = ~wc;
    chk(!req_ready, "R9", {tag, " ready low while busy"}, 64'(req_ready), 64'h0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    for (int k = 0; k < bp; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == held, "R9", {tag, " response held"},
          rsp_rdata, held);
    end

    n = tx_q.size();
    seq_ok = (n == exp_q.size());
    cs_ok = 1;
    for (int k = 0; k < n && seq_ok; k++)
      if (tx_q[k] !== exp_q[k]) begin
        seq_ok = 0;
        $display("  %s byte %0d sent %h wanted %h", tag, k, tx_q[k], exp_q[k]);
      end
    for (int k = 0; k < n; k++) if (csq[k] != exp_sel) cs_ok = 0;
    chk(seq_ok, "R1 R2 R4 R5 R6", {tag, " byte sequence (len)"},
        64'(n), 64'(exp_q.size()));
    chk(cs_ok, "R7", {tag, " select per byte"}, 64'(cs_ok), 64'h1);
    exp_rd = '0;
    if (!wr && n >= nb)
      for (int k = 0; k < nb; k++) exp_rd[8*k +: 8] = rx_q[n - nb + k];
    chk(rsp_rdata == exp_rd, "R5", {tag, " read data"}, rsp_rdata, exp_rd);
    chk(rsp_err_asize == (na == 0), "R3", {tag, " size error flag"},
        64'(rsp_err_asize), 64'(na == 0));
    chk(rsp_err_busy == busy, "R8", {tag, " busy error flag"},
        64'(rsp_err_busy), 64'(busy));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R9", {tag, " idle after response"},
        64'({req_ready, rsp_valid}), 64'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 2'b11 && !xfer_valid && !rsp_valid && req_ready, "R10",
        "reset state", 64'({cs_n, xfer_valid, rsp_valid, req_ready}), 64'h19);
    // R1 R2 R4: read, 3-byte address, D=1 A=0 -> 8 dummies, 4 bytes
    access(0, 0, 27'h12_3456, 4, '0, 32'h0000_100B, 32'h0000_0002, 0, 0, "rd3");
    // R2 R4: read, 4-byte address, D=3 A=2 -> 6 dummies, 8 bytes, device 1
    access(0, 1, 27'h5_A3C7E1, 8, '0, 32'h0001_32EC, 32'h0, 0, 3, "rd4");
    // R4: no dummies (D=0), single byte
    access(0, 1, 27'h7FF_FFFF, 1, '0, 32'h0000_0303, 32'h0, 0, 0, "rd1");
    // R4: D=3 A=1 -> 12 dummies, 3 bytes
    access(0, 0, 27'h00_0001, 3, '0, 32'h0000_3113, 32'h0, 0, 2, "rd12");
    // R6: write 3-byte address; read word requests dummies, must not matter
    access(1, 0, 27'h0A_BCDE, 3, 64'h0000_0000_00C3_B2A1, 32'h0000_3003,
           32'h0000_3302, 0, 0, "wr3");
    // R5 R6: write 4-byte address, 8 bytes
    access(1, 1, 27'h1_020304, 8, 64'h8877_6655_4433_2211, 32'h0,
           32'h0001_0012, 0, 1, "wr4");
    // R3: invalid address sizes, access still runs
    access(0, 0, 27'h33_4455, 2, '0, 32'h0002_1003, 32'h0, 0, 0, "rdbad");
    access(1, 1, 27'h33_4455, 5, 64'h00_0000_EEDD_CCBB_AA, 32'h0,
           32'h0003_0002, 0, 0, "wrbad");
    // R8: another select active at acceptance
    access(0, 1, 27'h44_0000, 2, '0, 32'h0000_000B, 32'h0, 1, 0, "busy");
    access(1, 0, 27'h44_0000, 1, 64'h7E, 32'h0, 32'h0000_0002, 1, 2, "wbusy");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule